// File: doc/BRIEF.md
# Accumulator ALU with Extension Register

This block is the arithmetic/logic core of a small accumulator datapath. It holds a 16-bit accumulator and a 16-bit extension register, plus four condition flags: zero, negative, overflow and carry. Each clock cycle a 4-bit operation code and a 16-bit bus operand arrive already decoded. The selected operation updates the accumulator, and for some operations also the extension register, together with its own subset of the flags.

The operations are:
- loading the complement of the operand;
- clearing the accumulator;
- add and subtract;
- bitwise AND and OR;
- a quiet add that leaves every flag alone;
- shifts and rotates of the accumulator alone;
- shifts and rotates of the accumulator and extension register together, as one 32-bit value with the accumulator as the upper half.

Bus arbitration, register-file selection and constant fetch belong to the surrounding sequencer.

Top module: `acc_ext_alu`

## Requirements
- R1: While `rstN` is low, the accumulator, the extension register and all four flags are zero.
- R2: Codes 0 and 15 are idle. They leave the accumulator, the extension register and all flags unchanged.
- R3: Code 1 loads the accumulator with the bitwise complement of `busIn` and leaves all flags unchanged.
- R4: Code 2 clears the accumulator, sets Z, clears N, and keeps O and C.
- R5: Code 3 writes accumulator + `busIn`. It updates Z, N, O and C, with C equal to the unsigned carry out and O set when both operands share a sign that the result does not.
- R6: Code 4 writes accumulator − `busIn` and updates Z, N, O and C.
  - C is 1 when the accumulator is unsigned greater than or equal to `busIn` (no borrow).
  - O is set when the operand signs differ and the result sign differs from the accumulator's sign.
- R7: Code 5 (AND) and code 6 (OR) combine the accumulator with `busIn`, update only Z and N, and keep O and C.
- R8: Code 7 writes accumulator + `busIn` and leaves all four flags unchanged.
- R9: Codes 8 to 11 act on the accumulator alone and update Z, N and C, leaving O unchanged.
  - Code 8: logical shift left, C = old bit 15.
  - Code 9: logical shift right, C = old bit 0.
  - Code 10: arithmetic shift right, C = old bit 0.
  - Code 11: rotate left by one, C = old bit 15.
- R10: Codes 12 to 14 act on {accumulator, extension} as one 32-bit value and update Z, N and C, leaving O unchanged. No other code changes the extension register.
  - Code 12: shift left, C = old bit 31.
  - Code 13: arithmetic shift right, C = old bit 0.
  - Code 14: rotate left, C = old bit 31.
- R11: After any operation that updates Z and N, N equals bit 15 of the new accumulator. Z is set when the result is zero: the 16-bit accumulator for single-width operations, the full 32-bit pair for codes 12 to 14.
- R12: All results become visible at the outputs after the rising clock edge that samples `opCode` and `busIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| opCode | input | 4 | Operation code for this cycle |
| busIn | input | 16 | Second operand |
| arOut | output | 16 | Accumulator |
| hrOut | output | 16 | Extension register |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| flagO | output | 1 | Signed overflow flag |
| flagC | output | 1 | Carry / no-borrow / shifted-out bit |

## Verification
Every result lives in a register, so the new accumulator, extension register and flags are due exactly one rising edge after the code and operand are presented. None is visible in the same cycle.

The bench drives each operation on a falling edge and lets one rising edge pass. It compares all outputs at the following falling edge, before the next code can act. A chained vector table carries state from row to row, so flag retention is seen directly. Directed steps then cover:
- the 32-bit zero rule;
- subtract equality;
- a reset in mid-run.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDINV = 4'd1,
    OP_CLR   = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_ADDQ  = 4'd7,
    OP_SHL   = 4'd8,
    OP_SHR   = 4'd9,
    OP_ASR   = 4'd10,
    OP_ROL   = 4'd11,
    OP_DSHL  = 4'd12,
    OP_DASR  = 4'd13,
    OP_DROL  = 4'd14,
    OP_IDLE  = 4'd15
  } opT;

  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_INV,
    SRC_ZERO,
    SRC_SUM,
    SRC_LOGIC,
    SRC_SHIFT
  } srcT;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2,
    SH_ROT   = 2'd3
  } shKindT;

  typedef struct packed {
    srcT    src;
    logic   subtract;
    logic   useOr;
    shKindT shKind;
    logic   wide;
    logic   wrAr;
    logic   wrHr;
    logic   updZN;
    logic   updO;
    logic   updC;
  } ctrlT;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [3:0] opCode,
  output ctrlT       ctl
);

  opT op;
  assign op = opT'(opCode);

  always_comb begin
    ctl = '{src: SRC_HOLD, subtract: 1'b0, useOr: 1'b0, shKind: SH_LEFT,
            wide: 1'b0, wrAr: 1'b0, wrHr: 1'b0, updZN: 1'b0, updO: 1'b0,
            updC: 1'b0};
    case (op)
      OP_LDINV: begin
        ctl.src  = SRC_INV;
        ctl.wrAr = 1'b1;
      end
      OP_CLR: begin
        ctl.src   = SRC_ZERO;
        ctl.wrAr  = 1'b1;
        ctl.updZN = 1'b1;
      end
      OP_ADD, OP_SUB: begin
        ctl.src      = SRC_SUM;
        ctl.subtract = (op == OP_SUB);
        ctl.wrAr     = 1'b1;
        ctl.updZN    = 1'b1;
        ctl.updO     = 1'b1;
        ctl.updC     = 1'b1;
      end
      OP_AND, OP_OR: begin
        ctl.src   = SRC_LOGIC;
        ctl.useOr = (op == OP_OR);
        ctl.wrAr  = 1'b1;
        ctl.updZN = 1'b1;
      end
      OP_ADDQ: begin
        ctl.src  = SRC_SUM;
        ctl.wrAr = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ASR, OP_ROL: begin
        ctl.src   = SRC_SHIFT;
        ctl.wrAr  = 1'b1;
        ctl.updZN = 1'b1;
        ctl.updC  = 1'b1;
        unique case (op)
          OP_SHL:  ctl.shKind = SH_LEFT;
          OP_SHR:  ctl.shKind = SH_RIGHT;
          OP_ASR:  ctl.shKind = SH_ARITH;
          default: ctl.shKind = SH_ROT;
        endcase
      end
      OP_DSHL, OP_DASR, OP_DROL: begin
        ctl.src   = SRC_SHIFT;
        ctl.wide  = 1'b1;
        ctl.wrAr  = 1'b1;
        ctl.wrHr  = 1'b1;
        ctl.updZN = 1'b1;
        ctl.updC  = 1'b1;
        unique case (op)
          OP_DSHL: ctl.shKind = SH_LEFT;
          OP_DASR: ctl.shKind = SH_ARITH;
          default: ctl.shKind = SH_ROT;
        endcase
      end
      default: ;
    endcase
  end

  always_comb begin
    assert (!(ctl.wrHr && !ctl.wide)) else $error("AST_HR_NEEDS_WIDE"); // R10
    assert (!(ctl.updO && !ctl.updZN)) else $error("AST_O_WITH_ZN");   // R9
  end

endmodule

// File: rtl/acc_alu_shifter.sv
module acc_alu_shifter
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] hiIn,
  input  logic [W-1:0] loIn,
  input  shKindT       kind,
  input  logic         wide,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut,
  output logic         outBit
);

  localparam int PW = 2 * W;

  logic [PW-1:0] pairIn;
  logic [PW-1:0] pairOut;

  assign pairIn = {hiIn, loIn};

  always_comb begin
    pairOut = pairIn;
    outBit  = 1'b0;
    if (wide) begin
      case (kind)
        SH_LEFT: begin
          pairOut = {pairIn[PW-2:0], 1'b0};
          outBit  = pairIn[PW-1];
        end
        SH_RIGHT, SH_ARITH: begin
          pairOut = {pairIn[PW-1], pairIn[PW-1:1]};
          outBit  = pairIn[0];
        end
        default: begin
          pairOut = {pairIn[PW-2:0], pairIn[PW-1]};
          outBit  = pairIn[PW-1];
        end
      endcase
    end else begin
      case (kind)
        SH_LEFT: begin
          pairOut[PW-1:W] = {hiIn[W-2:0], 1'b0};
          outBit          = hiIn[W-1];
        end
        SH_RIGHT: begin
          pairOut[PW-1:W] = {1'b0, hiIn[W-1:1]};
          outBit          = hiIn[0];
        end
        SH_ARITH: begin
          pairOut[PW-1:W] = {hiIn[W-1], hiIn[W-1:1]};
          outBit          = hiIn[0];
        end
        default: begin
          pairOut[PW-1:W] = {hiIn[W-2:0], hiIn[W-1]};
          outBit          = hiIn[W-1];
        end
      endcase
    end
  end

  assign hiOut = pairOut[PW-1:W];
  assign loOut = pairOut[W-1:0];

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlT         ctl,
  input  logic [W-1:0] busIn,
  output logic [W-1:0] arQ,
  output logic [W-1:0] hrQ,
  output logic         zQ,
  output logic         nQ,
  output logic         oQ,
  output logic         cQ
);

  logic [W-1:0] bOp;
  logic [W:0]   sum;
  logic         ovf;
  logic [W-1:0] logicRes;
  logic [W-1:0] shHi;
  logic [W-1:0] shLo;
  logic         shBit;
  logic [W-1:0] arNext;
  logic [W-1:0] hrNext;
  logic         zNext;
  logic         cNext;

  assign bOp = ctl.subtract ? ~busIn : busIn;
  assign sum = {1'b0, arQ} + {1'b0, bOp} + {{W{1'b0}}, ctl.subtract};
  assign ovf = (arQ[W-1] == bOp[W-1]) && (sum[W-1] != arQ[W-1]);
  assign logicRes = ctl.useOr ? (arQ | busIn) : (arQ & busIn);

  acc_alu_shifter #(.W(W)) shifter (
    .hiIn  (arQ),
    .loIn  (hrQ),
    .kind  (ctl.shKind),
    .wide  (ctl.wide),
    .hiOut (shHi),
    .loOut (shLo),
    .outBit(shBit)
  );

  always_comb begin
    hrNext = hrQ;
    case (ctl.src)
      SRC_INV:   arNext = ~busIn;
      SRC_ZERO:  arNext = '0;
      SRC_SUM:   arNext = sum[W-1:0];
      SRC_LOGIC: arNext = logicRes;
      SRC_SHIFT: begin
        arNext = shHi;
        hrNext = shLo;
      end
      default:   arNext = arQ;
    endcase
  end

  assign zNext = ctl.wide ? ({arNext, hrNext} == '0) : (arNext == '0);
  assign cNext = (ctl.src == SRC_SHIFT) ? shBit : sum[W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arQ <= '0;
      hrQ <= '0;
      zQ  <= 1'b0;
      nQ  <= 1'b0;
      oQ  <= 1'b0;
      cQ  <= 1'b0;
    end else begin
      if (ctl.wrAr) arQ <= arNext;
      if (ctl.wrHr) hrQ <= hrNext;
      if (ctl.updZN) begin
        zQ <= zNext;
        nQ <= arNext[W-1];
      end
      if (ctl.updO) oQ <= ovf;
      if (ctl.updC) cQ <= cNext;
    end
  end

  AST_HR_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrHr |=> $stable(hrQ)) else $error("AST_HR_WIDE_ONLY"); // R10
  AST_N_IS_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.updZN |=> (nQ == arQ[W-1])) else $error("AST_N_IS_SIGN"); // R11
  AST_Z_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.updZN && !ctl.wide) |=> (zQ == (arQ == '0))) else $error("AST_Z_NARROW"); // R11
  AST_O_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.updO |=> $stable(oQ)) else $error("AST_O_KEPT"); // R7

endmodule

// File: rtl/acc_ext_alu.sv
module acc_ext_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   opCode,
  input  logic [W-1:0] busIn,
  output logic [W-1:0] arOut,
  output logic [W-1:0] hrOut,
  output logic         flagZ,
  output logic         flagN,
  output logic         flagO,
  output logic         flagC
);

  ctrlT ctl;

  acc_alu_ctrl ctrl (
    .opCode(opCode),
    .ctl   (ctl)
  );

  acc_alu_datapath #(.W(W)) dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .busIn(busIn),
    .arQ  (arOut),
    .hrQ  (hrOut),
    .zQ   (flagZ),
    .nQ   (flagN),
    .oQ   (flagO),
    .cQ   (flagC)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_NOP || opCode == OP_IDLE) |=>
      ($stable(arOut) && $stable(hrOut) && $stable({flagZ, flagN, flagO, flagC})))
    else $error("AST_IDLE_HOLD"); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_CLR) |=> (arOut == '0 && flagZ && !flagN))
    else $error("AST_CLEAR_ZERO"); // R4
  AST_QUIET_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_ADDQ) |=> $stable({flagZ, flagN, flagO, flagC}))
    else $error("AST_QUIET_ADD"); // R8
  AST_INV_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_LDINV) |=> $stable({flagZ, flagN, flagO, flagC}))
    else $error("AST_INV_FLAGS"); // R3

endmodule

// File: tb/acc_ext_alu_test.sv
module acc_ext_alu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [15:0] busIn = 16'd0;
  logic [15:0] arOut;
  logic [15:0] hrOut;
  logic        flagZ, flagN, flagO, flagC;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_ext_alu uut (
    .clk   (clk),
    .rstN  (rstN),
    .opCode(opCode),
    .busIn (busIn),
    .arOut (arOut),
    .hrOut (hrOut),
    .flagZ (flagZ),
    .flagN (flagN),
    .flagO (flagO),
    .flagC (flagC)
  );

  // {op[55:52], bus[51:36], expAr[35:20], expHr[19:4], flags ZNOC[3:0]}
  localparam int NV = 22;
  localparam logic [55:0] VEC [NV] = '{
    {4'd1,  16'h00FF, 16'hFF00, 16'h0000, 4'b0000},
    {4'd3,  16'h0100, 16'h0000, 16'h0000, 4'b1001},
    {4'd3,  16'h7FFF, 16'h7FFF, 16'h0000, 4'b0000},
    {4'd3,  16'h0001, 16'h8000, 16'h0000, 4'b0110},
    {4'd4,  16'h0001, 16'h7FFF, 16'h0000, 4'b0011},
    {4'd4,  16'h8000, 16'hFFFF, 16'h0000, 4'b0110},
    {4'd5,  16'h0F0F, 16'h0F0F, 16'h0000, 4'b0010},
    {4'd6,  16'hF000, 16'hFF0F, 16'h0000, 4'b0110},
    {4'd7,  16'h00F1, 16'h0000, 16'h0000, 4'b0110},
    {4'd2,  16'h1234, 16'h0000, 16'h0000, 4'b1010},
    {4'd1,  16'h7FFE, 16'h8001, 16'h0000, 4'b1010},
    {4'd8,  16'h0000, 16'h0002, 16'h0000, 4'b0011},
    {4'd1,  16'h3FFF, 16'hC000, 16'h0000, 4'b0011},
    {4'd11, 16'h0000, 16'h8001, 16'h0000, 4'b0111},
    {4'd10, 16'h0000, 16'hC000, 16'h0000, 4'b0111},
    {4'd9,  16'h0000, 16'h6000, 16'h0000, 4'b0010},
    {4'd12, 16'h0000, 16'hC000, 16'h0000, 4'b0110},
    {4'd14, 16'h0000, 16'h8000, 16'h0001, 4'b0111},
    {4'd13, 16'h0000, 16'hC000, 16'h0000, 4'b0111},
    {4'd13, 16'h0000, 16'hE000, 16'h0000, 4'b0110},
    {4'd0,  16'hFFFF, 16'hE000, 16'h0000, 4'b0110},
    {4'd15, 16'hFFFF, 16'hE000, 16'h0000, 4'b0110}
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd15: return "R2";
      4'd1:        return "R3";
      4'd2:        return "R4";
      4'd3:        return "R5";
      4'd4:        return "R6";
      4'd5, 4'd6:  return "R7";
      4'd7:        return "R8";
      4'd8, 4'd9, 4'd10, 4'd11: return "R9";
      default:     return "R10";
    endcase
  endfunction

  task automatic checkState(input string req, input logic [15:0] expAr,
                            input logic [15:0] expHr, input logic [3:0] expFlags);
    logic [3:0] gotFlags;
    gotFlags = {flagZ, flagN, flagO, flagC};
    checks++;
    if (arOut !== expAr || hrOut !== expHr || gotFlags !== expFlags) begin
      errors++;
      $display("FAIL %s: ar=%h hr=%h znoc=%b, expected ar=%h hr=%h znoc=%b",
               req, arOut, hrOut, gotFlags, expAr, expHr, expFlags);
    end
  endtask

  // Drive at a falling edge; one rising edge registers it; result sampled at the next falling edge (R12).
  task automatic step(input logic [3:0] op, input logic [15:0] bus);
    opCode = op;
    busIn  = bus;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN   = 1'b0;
    opCode = 4'd0;
    busIn  = 16'h0000;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    checkState("R1", 16'h0000, 16'h0000, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][55:52], VEC[i][51:36]);
      checkState(reqOf(VEC[i][55:52]), VEC[i][35:20], VEC[i][19:4], VEC[i][3:0]);
    end

    // R12: result not visible before the sampling edge
    opCode = 4'd1;
    busIn  = 16'h0000;
    #1;
    checkState("R12", 16'hE000, 16'h0000, 4'b0110);
    @(posedge clk);
    @(negedge clk);
    checkState("R12", 16'hFFFF, 16'h0000, 4'b0110);

    // R1: reset in mid-run clears everything
    doReset();
    checkState("R1", 16'h0000, 16'h0000, 4'b0000);

    // R6: equal operands give zero, no borrow, no overflow
    step(4'd1, 16'hFFFA);
    checkState("R3", 16'h0005, 16'h0000, 4'b0000);
    step(4'd4, 16'h0005);
    checkState("R6", 16'h0000, 16'h0000, 4'b1001);

    // R11 / R10: 32-bit zero rule
    step(4'd1, 16'h7FFF);
    checkState("R3", 16'h8000, 16'h0000, 4'b1001);
    step(4'd14, 16'h0000);
    checkState("R11", 16'h0000, 16'h0001, 4'b0001);
    step(4'd13, 16'h0000);
    checkState("R11", 16'h0000, 16'h0000, 4'b1001);
    step(4'd1, 16'h7FFF);
    step(4'd12, 16'h0000);
    checkState("R10", 16'h0000, 16'h0000, 4'b1001);

    // R9: single shift leaves extension register alone while it is nonzero
    step(4'd1, 16'h7FFF);
    step(4'd14, 16'h0000);
    step(4'd1, 16'hFFFE);
    step(4'd9, 16'h0000);
    checkState("R9", 16'h0000, 16'h0001, 4'b1001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule